// File: doc/BRIEF.md
# Bit-Matrix Least-Recently-Used Replacement Tracker

This block keeps the recency history of every set of an N-way set-associative cache. Each set owns a square grid of single-bit flops, one row per way. When the cache touches a way, whether on a hit or on a fill, the owning controller pulses an access strobe with the set index and the way number. The grid of that set is rewritten on the next clock edge: the row of the touched way is filled with ones, and then the column of that way is wiped to zero. The number of ones in a row therefore ranks the ways by how recently they were used.

A separate query set index selects one grid. From it the block combinationally reports the victim, which is the way whose row holds no ones, and the most recently used way, which is the row with the most ones. Tag matching, data arrays and miss sequencing live elsewhere. The way number always comes from outside the block.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After reset, every set reports victim way 0 and most-recently-used way 0.
- R2: One cycle after an access to way k of set s (the edge that samples `acc_valid`=1), querying set s reports way k as the most-recently-used way.
- R3: Once every way of a set has been touched, the victim of that set is the way whose last access is the oldest. Ways never touched since reset are chosen before any touched way.
- R4: When several ways of a set are untouched since reset, the victim is the lowest-numbered of them. When several rows tie for the most ones (only possible at reset), the most-recently-used output is the lowest-numbered of them.
- R5: An access to one set leaves the victim and most-recently-used outputs of every other set unchanged.
- R6: Accessing the way that is already most recently used leaves the victim and the most-recently-used way of that set unchanged.
- R7: While `acc_valid` is 0, no set's history changes, whatever `acc_set` and `acc_way` carry.
- R8: `victim_way` and `mru_way` follow `qry_set` combinationally, in the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all history |
| acc_valid | input | 1 | Access strobe; one access per cycle while high |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way touched by the access |
| qry_set | input | SET_W | Set whose history drives the outputs |
| victim_way | output | WAY_W | Least-recently-used way of the queried set |
| mru_way | output | WAY_W | Most-recently-used way of the queried set |

## Verification
Touching the ways of one set in ascending order and then in reverse separates a true recency ordering from a fixed or rotating pointer. It also exposes swapped row and column updates, because the victim must move to the oldest way after each step. Back-to-back accesses to one way, and accesses to a neighbouring set, show that the grid of the addressed set alone changes, and that re-touching the newest way leaves the order alone. A long pseudo-random access stream spread over all sets, with frequent repeats, is compared against a timestamp model in the bench. This catches ordering faults that only appear after many interleaved updates, and holding the strobe low with live set and way values shows that the strobe gates every write.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // widest grid row supported by the popcount helper
  localparam int unsigned ROW_MAX = 64;
  localparam int unsigned CNT_W   = 7;

  typedef logic [ROW_MAX-1:0] row_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // number of ones in a row, used to rank recency
  function automatic cnt_t row_ones(input row_t r);
    cnt_t acc;
    acc = '0;
    for (int b = 0; b < ROW_MAX; b++) begin
      acc = acc + cnt_t'(r[b]);
    end
    return acc;
  endfunction
endpackage

// File: rtl/lru_set_grid.sv
module lru_set_grid #(
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned BITS  = WAYS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_way,
  output logic [BITS-1:0]  grid
);
  // row r occupies grid[r*WAYS +: WAYS]; bit c of that row is column c
  logic [BITS-1:0] grid_next;

  always_comb begin
    grid_next = grid;
    for (int r = 0; r < WAYS; r++) begin
      for (int c = 0; c < WAYS; c++) begin
        if (c == int'(upd_way)) begin
          grid_next[r*WAYS + c] = 1'b0;     // column wipe wins
        end else if (r == int'(upd_way)) begin
          grid_next[r*WAYS + c] = 1'b1;     // row fill
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid <= '0;
    end else if (upd_en) begin
      grid <= grid_next;
    end
  end
endmodule

// File: rtl/lru_row_scan.sv
module lru_row_scan
  import lru_pkg::*;
#(
  parameter int unsigned WAYS  = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned BITS  = WAYS * WAYS
) (
  input  logic [BITS-1:0]  grid,
  output logic [WAYS-1:0]  zero_rows,
  output logic [WAY_W-1:0] victim,
  output logic [WAY_W-1:0] newest
);
  cnt_t ones [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_row
    assign ones[g]      = row_ones(row_t'(grid[g*WAYS +: WAYS]));
    assign zero_rows[g] = (grid[g*WAYS +: WAYS] == '0);
  end

  // lowest-numbered empty row
  always_comb begin
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (zero_rows[i]) victim = WAY_W'(i);
    end
  end

  // lowest-numbered row holding the most ones
  always_comb begin
    cnt_t best;
    best   = ones[0];
    newest = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (ones[i] > best) begin
        best   = ones[i];
        newest = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 8,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned BITS  = WAYS * WAYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [SET_W-1:0] qry_set,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAY_W-1:0] mru_way
);
  logic [BITS-1:0] set_grid [SETS];
  logic [SETS-1:0] set_hit;
  logic [BITS-1:0] sel_grid;   // grid of the queried set
  logic [WAYS-1:0] sel_zero;   // empty rows of the queried set

  for (genvar s = 0; s < SETS; s++) begin : g_set
    assign set_hit[s] = acc_valid && (acc_set == SET_W'(s));
    lru_set_grid #(.WAYS(WAYS)) u_grid (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_en  (set_hit[s]),
      .upd_way (acc_way),
      .grid    (set_grid[s])
    );
  end

  assign sel_grid = set_grid[qry_set];

  lru_row_scan #(.WAYS(WAYS)) u_scan (
    .grid      (sel_grid),
    .zero_rows (sel_zero),
    .victim    (victim_way),
    .newest    (mru_way)
  );
endmodule

// File: rtl/lru_tracker_checker.sv
module lru_tracker_checker #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 8,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned BITS  = WAYS * WAYS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic [SET_W-1:0] qry_set,
  input logic [WAY_W-1:0] victim_way,
  input logic [WAY_W-1:0] mru_way,
  input logic [BITS-1:0]  sel_grid,
  input logic [WAYS-1:0]  sel_zero
);
  // R2: the touched way becomes the newest of its set
  assert_newest_after_touch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_set == qry_set) |=> ($stable(qry_set) -> mru_way == $past(acc_way)));

  // R3: the way just touched is never the victim
  assert_victim_not_fresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_set == qry_set) |=> ($stable(qry_set) -> victim_way != $past(acc_way)));

  // R3: the reported victim owns an empty history row
  assert_victim_row_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_grid[victim_way*WAYS +: WAYS]) == 0);

  // R4: no empty row below the victim
  assert_victim_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_zero & ((WAYS'(1) << victim_way) - WAYS'(1))) == '0);

  // R7: without a strobe the queried history holds
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid) |=> ($stable(qry_set) -> ($stable(victim_way) && $stable(mru_way))));

  // R5: touching another set leaves the queried one alone
  assert_other_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_set != qry_set) |=> ($stable(qry_set) -> $stable(sel_grid)));
endmodule

bind lru_matrix_tracker lru_tracker_checker #(.WAYS(WAYS), .SETS(SETS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_set    (acc_set),
  .acc_way    (acc_way),
  .qry_set    (qry_set),
  .victim_way (victim_way),
  .mru_way    (mru_way),
  .sel_grid   (sel_grid),
  .sel_zero   (sel_zero)
);

// File: tb/tb_lru_matrix_tracker.sv
module tb_lru_matrix_tracker;
  localparam int WAYS  = 4;
  localparam int SETS  = 8;
  localparam int WAY_W = $clog2(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [SET_W-1:0] acc_set = '0;
  logic [WAY_W-1:0] acc_way = '0;
  logic [SET_W-1:0] qry_set = '0;
  logic [WAY_W-1:0] victim_way;
  logic [WAY_W-1:0] mru_way;

  int n_checks = 0;
  int n_fail   = 0;
  int stamp [SETS][WAYS];   // last-touch time per way, 0 = never
  int now = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  lru_matrix_tracker #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way), .mru_way(mru_way)
  );

  function automatic int exp_victim(input int s);
    int v = -1;
    for (int w = 0; w < WAYS; w++) if (stamp[s][w] == 0 && v < 0) v = w;
    if (v >= 0) return v;
    v = 0;
    for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][v]) v = w;
    return v;
  endfunction

  function automatic int exp_mru(input int s);
    int m = 0;
    for (int w = 1; w < WAYS; w++) if (stamp[s][w] > stamp[s][m]) m = w;
    return m;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // query a set and compare both outputs with the model
  task automatic probe(input int s, input string req);
    @(negedge clk);
    qry_set = SET_W'(s);
    #1;
    check({req, " victim"}, int'(victim_way), exp_victim(s));
    check({req, " mru"}, int'(mru_way), exp_mru(s));
  endtask

  task automatic touch(input int s, input int w);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_set   = SET_W'(s);
    acc_way   = WAY_W'(w);
    @(posedge clk);
    now++;
    stamp[s][w] = now;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < SETS; s++) probe(s, "R1/R4 reset");
  endtask

  task automatic t_order;
    for (int w = 0; w < WAYS; w++) begin
      touch(2, w);
      probe(2, "R2/R4 ascending");
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      touch(2, w);
      probe(2, "R3 descending");
    end
    touch(2, 1);
    probe(2, "R3 middle touch");
  endtask

  task automatic t_repeat;
    int v0, m0;
    touch(2, 3);
    @(negedge clk); qry_set = 2; #1;
    v0 = int'(victim_way); m0 = int'(mru_way);
    for (int k = 0; k < 3; k++) begin
      touch(2, 3);
      @(negedge clk); qry_set = 2; #1;
      check("R6 repeat victim", int'(victim_way), v0);
      check("R6 repeat mru", int'(mru_way), m0);
    end
  endtask

  task automatic t_isolation;
    touch(5, 2);
    touch(5, 0);
    probe(2, "R5 neighbour set 2");
    probe(4, "R5 untouched set 4");
    probe(5, "R5 touched set 5");
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      acc_set = SET_W'(k); acc_way = WAY_W'(k);
      @(negedge clk);
    end
    for (int s = 0; s < SETS; s++) probe(s, "R7 idle strobe");
  endtask

  task automatic t_comb;
    @(negedge clk);
    qry_set = 5; #1;
    check("R8 comb set5 mru", int'(mru_way), exp_mru(5));
    qry_set = 2; #1;
    check("R8 comb set2 mru", int'(mru_way), exp_mru(2));
    qry_set = 7; #1;
    check("R8 comb set7 victim", int'(victim_way), exp_victim(7));
  endtask

  task automatic t_random;
    int s, w;
    for (int k = 0; k < 1500; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = int'(lfsr[2:0]);
      w = (lfsr[7:6] == 2'b00) ? exp_mru(s) : int'(lfsr[5:4]);
      touch(s, w);
      probe(int'(lfsr[10:8]), "R2/R3 random");
    end
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) stamp[s][w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_repeat();
    t_isolation();
    t_idle();
    t_comb();
    t_random();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule